// File: doc/BRIEF.md
# Port Width Adapter with Lane Steering and Byte Reordering

This block sits between a 36-bit first-in first-out store and an external data port whose active width can be 36, 18 or 9 bits. On the write side it gathers narrow beats into full 36-bit words and hands each finished word to the store with a one-cycle strobe. On the read side it takes the word at the head of the store and presents it as one, two or four narrow beats. It asks for the next word only when the last beat of the current one has gone out.

A byte is 9 bits, and a full word holds four byte lanes. Lane 3 is bits 35:27 and lane 0 is bits 8:0. A lane-steering input chooses which lanes of the external bus carry narrow transfers. The same input sets the order in which lanes fill. A two-bit reorder code rearranges the four bytes of every word and works with every width. A size code of all ones sends the transfer to a side mailbox path instead of the store. Width, steering and reorder settings are sampled only at the start of a word and hold until that word is complete.

Top module: `lane_adapter`

## Requirements
- R1: After synchronous reset, both sides stand at a word boundary and `wr_word_vld`, `wr_mbox_vld`, `rd_pop` and `rd_mbox_take` are low.
- R2: With size code 00 (36 bits), every accepted write beat drives `wr_word_vld` high for exactly the following cycle, with `wr_word` equal to the reordered bus value.
- R3: With size code 01 (18 bits), two write beats form one word. When `lo_lanes`=0 the data comes from bus bits 35:18, and the first beat fills word bits 35:18. When `lo_lanes`=1 the data comes from bus bits 17:0, and the first beat fills word bits 17:0.
- R4: With size code 10 (9 bits), four write beats form one word. When `lo_lanes`=0 the data comes from lane 3 of the bus, and the beats fill lanes 3, 2, 1, 0 in that order. When `lo_lanes`=1 the data comes from lane 0, and the beats fill lanes 0, 1, 2, 3.
- R5: Reorder code `swap_sel` sets lane i of the result to lane (i XOR m) of the source, with m=0 for code 00, m=3 for code 01 (full reversal), m=2 for code 10 (half exchange) and m=1 for code 11 (byte exchange within each half). It applies to packed write words and to the head word before unpacking.
- R6: With size code 00 on the read side, `rd_bus` equals the reordered `rd_head`, and `rd_pop` is high in every cycle with `rd_en` high.
- R7: With size code 01 or 10 on the read side, the beats come out in the lane order of R3 and R4, on the lanes chosen by `lo_lanes`. Lanes that carry no data are zero. `rd_pop` is high only on the final beat of a word.
- R8: A change of size, steering or reorder code in the middle of a word does not affect that word. It takes effect at the next word boundary.
- R9: Size code 11 at a word boundary selects the mailbox. A write beat then raises `wr_mbox_vld` for one cycle with `wr_word` equal to the raw bus, and `wr_word_vld` stays low. A read then shows `rd_mbox` on `rd_bus` and raises `rd_mbox_take`, and `rd_pop` stays low.
- R10: Cycles with the enable low neither advance the beat position nor raise any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, all actions on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Width code: 00 36-bit, 01 18-bit, 10 9-bit, 11 mailbox |
| lo_lanes | input | 1 | 0: narrow data on upper lanes, upper lane first; 1: lower lanes, lower lane first |
| swap_sel | input | 2 | Byte reorder code |
| wr_en | input | 1 | Write beat enable |
| wr_bus | input | 36 | Write data from the external bus |
| wr_word | output | 36 | Packed word or raw mailbox value |
| wr_word_vld | output | 1 | One-cycle strobe, packed word ready for the store |
| wr_mbox_vld | output | 1 | One-cycle strobe, mailbox value ready |
| rd_en | input | 1 | Read beat enable |
| rd_head | input | 36 | Word at the head of the store |
| rd_mbox | input | 36 | Mailbox contents |
| rd_bus | output | 36 | Read data toward the external bus |
| rd_pop | output | 1 | Advance request to the store |
| rd_mbox_take | output | 1 | Mailbox read strobe |

## Verification
The bench builds the adapter with its default 9-bit lane width. With that setting the word is exactly four lanes, so every lane position, each of the four reorder codes, and both steering choices give distinct, recognisable bus patterns. Filler values in the unused bus lanes show that unused lanes are ignored. Changing settings mid-word and idle gaps between beats reach the boundary-sampling and beat-hold corners.

// File: rtl/lane_adapter_pkg.sv
package lane_adapter_pkg;

    localparam int LANE_W_DEF = 9;
    localparam int LANES      = 4;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_MBOX = 2'b11
    } size_e;

    typedef struct packed {
        size_e      sz;
        logic [1:0] sw;
        logic       lo;
    } cfg_t;

    // lane index xor mask for each reorder code
    function automatic logic [1:0] swap_mask(input logic [1:0] code);
        logic [1:0] m;
        case (code)
            2'b01:   m = 2'd3;
            2'b10:   m = 2'd2;
            2'b11:   m = 2'd1;
            default: m = 2'd0;
        endcase
        return m;
    endfunction

    function automatic logic [1:0] final_beat(input size_e sz);
        logic [1:0] b;
        case (sz)
            SZ_WORD: b = 2'd1;
            SZ_BYTE: b = 2'd3;
            default: b = 2'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/la_beat_ctl.sv
module la_beat_ctl
    import lane_adapter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  cfg_t       cfg_in,
    output cfg_t       cfg_eff,
    output logic [1:0] beat,
    output logic       last,
    output logic       mbox
);

    cfg_t       held_q;
    logic [1:0] beat_q;

    assign beat    = beat_q;
    assign cfg_eff = (beat_q == 2'd0) ? cfg_in : held_q;
    assign mbox    = (cfg_eff.sz == SZ_MBOX);
    assign last    = (beat_q == final_beat(cfg_eff.sz));

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= 2'd0;
            held_q <= '0;
        end else if (step) begin
            if (beat_q == 2'd0)
                held_q <= cfg_in;
            if (mbox || last)
                beat_q <= 2'd0;
            else
                beat_q <= beat_q + 2'd1;
        end
    end

    // R8: settings frozen while a word is in progress
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (beat_q != 2'd0) |-> $stable(cfg_eff));

    // R10: no beat movement without an enable
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(step) |-> $stable(beat_q));

endmodule

// File: rtl/la_pack.sv
module la_pack
    import lane_adapter_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    localparam int WORD_W = LANES * LANE_W,
    localparam int HALF_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] bus,
    input  cfg_t              cfg,
    input  logic [1:0]        beat,
    input  logic              last,
    input  logic              mbox,
    output logic [WORD_W-1:0] word,
    output logic              vld,
    output logic              mvld
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] reordered;
    logic [WORD_W-1:0] word_q;
    logic              vld_q;
    logic              mvld_q;
    logic [1:0]        lane_tgt;
    logic              half_tgt;
    logic [1:0]        mask;

    assign lane_tgt = cfg.lo ? beat : (2'd3 - beat);
    assign half_tgt = cfg.lo ? beat[0] : ~beat[0];
    assign mask     = swap_mask(cfg.sw);

    always_comb begin
        merged = acc_q;
        case (cfg.sz)
            SZ_WORD: begin
                if (cfg.lo)
                    merged[half_tgt*HALF_W +: HALF_W] = bus[HALF_W-1:0];
                else
                    merged[half_tgt*HALF_W +: HALF_W] = bus[WORD_W-1 -: HALF_W];
            end
            SZ_BYTE: begin
                if (cfg.lo)
                    merged[lane_tgt*LANE_W +: LANE_W] = bus[LANE_W-1:0];
                else
                    merged[lane_tgt*LANE_W +: LANE_W] = bus[WORD_W-1 -: LANE_W];
            end
            default: merged = bus;
        endcase
    end

    always_comb begin
        for (int i = 0; i < LANES; i++)
            reordered[i*LANE_W +: LANE_W] = merged[(i ^ int'(mask))*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
            mvld_q <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            mvld_q <= 1'b0;
            if (en && mbox) begin
                word_q <= bus;
                mvld_q <= 1'b1;
            end else if (en) begin
                acc_q <= merged;
                if (last) begin
                    word_q <= reordered;
                    vld_q  <= 1'b1;
                end
            end
        end
    end

    assign word = word_q;
    assign vld  = vld_q;
    assign mvld = mvld_q;

    // R9: store and mailbox strobes never together
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vld_q, mvld_q}));

    // R2: a word strobe always follows an accepted beat
    a_r2_vld_after_beat: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> $past(en));

    // R10: strobes last a single cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q || $past(en));

endmodule

// File: rtl/la_unpack.sv
module la_unpack
    import lane_adapter_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    localparam int WORD_W = LANES * LANE_W,
    localparam int HALF_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] head,
    input  logic [WORD_W-1:0] mbox_word,
    input  cfg_t              cfg,
    input  logic [1:0]        beat,
    input  logic              last,
    input  logic              mbox,
    output logic [WORD_W-1:0] bus,
    output logic              pop,
    output logic              take
);

    logic [WORD_W-1:0] src;
    logic [1:0]        mask;
    logic [1:0]        lane_src;
    logic              half_src;

    assign mask     = swap_mask(cfg.sw);
    assign lane_src = cfg.lo ? beat : (2'd3 - beat);
    assign half_src = cfg.lo ? beat[0] : ~beat[0];

    always_comb begin
        for (int i = 0; i < LANES; i++)
            src[i*LANE_W +: LANE_W] = head[(i ^ int'(mask))*LANE_W +: LANE_W];
    end

    always_comb begin
        bus = '0;
        case (cfg.sz)
            SZ_WORD: begin
                if (cfg.lo)
                    bus[HALF_W-1:0] = src[half_src*HALF_W +: HALF_W];
                else
                    bus[WORD_W-1 -: HALF_W] = src[half_src*HALF_W +: HALF_W];
            end
            SZ_BYTE: begin
                if (cfg.lo)
                    bus[LANE_W-1:0] = src[lane_src*LANE_W +: LANE_W];
                else
                    bus[WORD_W-1 -: LANE_W] = src[lane_src*LANE_W +: LANE_W];
            end
            SZ_MBOX: bus = mbox_word;
            default: bus = src;
        endcase
    end

    assign pop  = en && last && !mbox;
    assign take = en && mbox;

    // R7: in upper-lane byte mode the three lower lanes are idle
    a_r7_idle_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg.sz == SZ_BYTE && !cfg.lo) |-> (bus[WORD_W-LANE_W-1:0] == '0));

    // R9: store advance and mailbox read are exclusive
    a_r9_pop_take_excl: assert property (@(posedge clk) disable iff (rst)
        !(pop && take));

endmodule

// File: rtl/lane_adapter.sv
module lane_adapter
    import lane_adapter_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_sel,
    input  logic              lo_lanes,
    input  logic [1:0]        swap_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_bus,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_word_vld,
    output logic              wr_mbox_vld,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_head,
    input  logic [WORD_W-1:0] rd_mbox,
    output logic [WORD_W-1:0] rd_bus,
    output logic              rd_pop,
    output logic              rd_mbox_take
);

    cfg_t       cfg_in;
    cfg_t       wcfg, rcfg;
    logic [1:0] wbeat, rbeat;
    logic       wlast, rlast, wmbox, rmbox;

    assign cfg_in = '{sz: size_e'(size_sel), sw: swap_sel, lo: lo_lanes};

    la_beat_ctl u_wctl (
        .clk(clk), .rst(rst), .step(wr_en), .cfg_in(cfg_in),
        .cfg_eff(wcfg), .beat(wbeat), .last(wlast), .mbox(wmbox)
    );

    la_beat_ctl u_rctl (
        .clk(clk), .rst(rst), .step(rd_en), .cfg_in(cfg_in),
        .cfg_eff(rcfg), .beat(rbeat), .last(rlast), .mbox(rmbox)
    );

    la_pack #(.LANE_W(LANE_W)) u_pack (
        .clk(clk), .rst(rst), .en(wr_en), .bus(wr_bus), .cfg(wcfg),
        .beat(wbeat), .last(wlast), .mbox(wmbox),
        .word(wr_word), .vld(wr_word_vld), .mvld(wr_mbox_vld)
    );

    la_unpack #(.LANE_W(LANE_W)) u_unpack (
        .clk(clk), .rst(rst), .en(rd_en), .head(rd_head), .mbox_word(rd_mbox),
        .cfg(rcfg), .beat(rbeat), .last(rlast), .mbox(rmbox),
        .bus(rd_bus), .pop(rd_pop), .take(rd_mbox_take)
    );

endmodule

// File: tb/lane_adapter_tb.sv
module lane_adapter_tb_top;

    localparam int CLK_P = 10;
    localparam int LW    = 9;
    localparam int WW    = 4 * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    size_sel = 2'b00;
    logic          lo_lanes = 1'b0;
    logic [1:0]    swap_sel = 2'b00;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_bus = '0;
    logic [WW-1:0] wr_word;
    logic          wr_word_vld, wr_mbox_vld;
    logic          rd_en = 1'b0;
    logic [WW-1:0] rd_head = '0;
    logic [WW-1:0] rd_mbox = '0;
    logic [WW-1:0] rd_bus;
    logic          rd_pop, rd_mbox_take;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    lane_adapter dut_i (
        .clk(clk), .rst(rst), .size_sel(size_sel), .lo_lanes(lo_lanes),
        .swap_sel(swap_sel), .wr_en(wr_en), .wr_bus(wr_bus), .wr_word(wr_word),
        .wr_word_vld(wr_word_vld), .wr_mbox_vld(wr_mbox_vld), .rd_en(rd_en),
        .rd_head(rd_head), .rd_mbox(rd_mbox), .rd_bus(rd_bus), .rd_pop(rd_pop),
        .rd_mbox_take(rd_mbox_take)
    );

    function automatic logic [WW-1:0] w4(input logic [LW-1:0] l3, l2, l1, l0);
        return {l3, l2, l1, l0};
    endfunction

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write beat, entered and left at a falling edge
    task automatic wbeat(input logic [WW-1:0] d);
        wr_en  = 1'b1;
        wr_bus = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rstep;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 word strobe", {35'd0, wr_word_vld}, '0);
        chk("R1 mbox strobe", {35'd0, wr_mbox_vld}, '0);
        chk("R1 pop idle", {35'd0, rd_pop}, '0);
        chk("R1 take idle", {35'd0, rd_mbox_take}, '0);
    endtask

    task automatic t_long_write;
        size_sel = 2'b00; swap_sel = 2'b00;
        wbeat(36'h1_2345_6789);
        chk("R2 vld", {35'd0, wr_word_vld}, 36'd1);
        chk("R2 word", wr_word, 36'h1_2345_6789);
        wbeat(36'hF_EDCB_A987);
        chk("R2 back-to-back word", wr_word, 36'hF_EDCB_A987);
        @(posedge clk); @(negedge clk);
        chk("R2 strobe one cycle", {35'd0, wr_word_vld}, '0);
    endtask

    task automatic t_word_write;
        size_sel = 2'b01; swap_sel = 2'b00; lo_lanes = 1'b0;
        wbeat(w4(9'h1A1, 9'h1A2, 9'h055, 9'h0AA));
        chk("R3 no strobe after first half", {35'd0, wr_word_vld}, '0);
        wbeat(w4(9'h1B1, 9'h1B2, 9'h033, 9'h0CC));
        chk("R3 upper lanes", wr_word, w4(9'h1A1, 9'h1A2, 9'h1B1, 9'h1B2));
        lo_lanes = 1'b1;
        wbeat(w4(9'h055, 9'h0AA, 9'h0C1, 9'h0C2));
        wbeat(w4(9'h033, 9'h0CC, 9'h0D1, 9'h0D2));
        chk("R3 lower lanes", wr_word, w4(9'h0D1, 9'h0D2, 9'h0C1, 9'h0C2));
        chk("R3 vld", {35'd0, wr_word_vld}, 36'd1);
    endtask

    task automatic t_byte_write;
        size_sel = 2'b10; swap_sel = 2'b00; lo_lanes = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wbeat(w4(9'h101 + 9'(k), 9'h155, 9'h0AA, 9'h1FF));
            if (k < 3) chk("R4 no early strobe", {35'd0, wr_word_vld}, '0);
        end
        chk("R4 upper first", wr_word, w4(9'h101, 9'h102, 9'h103, 9'h104));
        lo_lanes = 1'b1;
        for (int k = 0; k < 4; k++)
            wbeat(w4(9'h155, 9'h0AA, 9'h1FF, 9'h011 + 9'(k)));
        chk("R4 lower first", wr_word, w4(9'h014, 9'h013, 9'h012, 9'h011));
    endtask

    task automatic t_swap_write;
        logic [WW-1:0] src;
        src = w4(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0);
        size_sel = 2'b00; lo_lanes = 1'b0;
        swap_sel = 2'b01; wbeat(src);
        chk("R5 reverse", wr_word, w4(9'h0D0, 9'h0C0, 9'h0B0, 9'h0A0));
        swap_sel = 2'b10; wbeat(src);
        chk("R5 halves", wr_word, w4(9'h0C0, 9'h0D0, 9'h0A0, 9'h0B0));
        swap_sel = 2'b11; wbeat(src);
        chk("R5 within halves", wr_word, w4(9'h0B0, 9'h0A0, 9'h0D0, 9'h0C0));
        // reorder combined with byte packing
        size_sel = 2'b10; swap_sel = 2'b01;
        for (int k = 0; k < 4; k++)
            wbeat(w4(9'h021 + 9'(k), 9'h0, 9'h0, 9'h0));
        chk("R5 byte mode reverse", wr_word, w4(9'h024, 9'h023, 9'h022, 9'h021));
        swap_sel = 2'b00;
    endtask

    task automatic t_long_read;
        size_sel = 2'b00; swap_sel = 2'b10; lo_lanes = 1'b0;
        rd_head = w4(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0);
        rd_en = 1'b1;
        #1;
        chk("R6 long read halves swapped", rd_bus, w4(9'h0C0, 9'h0D0, 9'h0A0, 9'h0B0));
        chk("R6 pop each beat", {35'd0, rd_pop}, 36'd1);
        rstep();
        rd_en = 1'b0; swap_sel = 2'b00;
        #1;
        chk("R10 no pop when idle", {35'd0, rd_pop}, '0);
    endtask

    task automatic t_narrow_read;
        logic [WW-1:0] exp;
        size_sel = 2'b10; swap_sel = 2'b00; lo_lanes = 1'b0;
        rd_head = w4(9'h1A1, 9'h1B2, 9'h1C3, 9'h1D4);
        rd_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            case (k)
                0: exp = w4(9'h1A1, 0, 0, 0);
                1: exp = w4(9'h1B2, 0, 0, 0);
                2: exp = w4(9'h1C3, 0, 0, 0);
                default: exp = w4(9'h1D4, 0, 0, 0);
            endcase
            chk("R7 byte read upper", rd_bus, exp);
            chk("R7 pop only at last", {35'd0, rd_pop}, (k == 3) ? 36'd1 : 36'd0);
            rstep();
        end
        size_sel = 2'b01; lo_lanes = 1'b1;
        #1;
        chk("R7 word read lower first", rd_bus, w4(0, 0, 9'h1C3, 9'h1D4));
        chk("R7 no pop first half", {35'd0, rd_pop}, '0);
        rstep();
        #1;
        chk("R7 word read lower second", rd_bus, w4(0, 0, 9'h1A1, 9'h1B2));
        chk("R7 pop second half", {35'd0, rd_pop}, 36'd1);
        rstep();
        rd_en = 1'b0;
    endtask

    task automatic t_cfg_hold;
        size_sel = 2'b10; swap_sel = 2'b00; lo_lanes = 1'b0;
        wbeat(w4(9'h061, 0, 0, 9'h1EE));
        size_sel = 2'b00; lo_lanes = 1'b1; swap_sel = 2'b01;
        wbeat(w4(9'h062, 0, 0, 9'h1EE));
        chk("R8 width change ignored mid-word", {35'd0, wr_word_vld}, '0);
        wbeat(w4(9'h063, 0, 0, 9'h1EE));
        wbeat(w4(9'h064, 0, 0, 9'h1EE));
        chk("R8 old settings kept", wr_word, w4(9'h061, 9'h062, 9'h063, 9'h064));
        wbeat(w4(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0));
        chk("R8 new settings at boundary", wr_word, w4(9'h0D0, 9'h0C0, 9'h0B0, 9'h0A0));
        swap_sel = 2'b00; lo_lanes = 1'b0;
    endtask

    task automatic t_idle;
        size_sel = 2'b01; lo_lanes = 1'b0;
        wbeat(w4(9'h071, 9'h072, 0, 0));
        repeat (3) begin
            rstep();
            chk("R10 idle no strobe", {35'd0, wr_word_vld}, '0);
        end
        wbeat(w4(9'h073, 9'h074, 0, 0));
        chk("R10 beat position held", wr_word, w4(9'h071, 9'h072, 9'h073, 9'h074));
    endtask

    task automatic t_mailbox;
        size_sel = 2'b11; swap_sel = 2'b01; lo_lanes = 1'b1;
        wbeat(36'h9_8765_4321);
        chk("R9 mbox strobe", {35'd0, wr_mbox_vld}, 36'd1);
        chk("R9 no word strobe", {35'd0, wr_word_vld}, '0);
        chk("R9 raw value", wr_word, 36'h9_8765_4321);
        rd_mbox = 36'h3_1415_9265; rd_head = 36'h0_0000_0001;
        rd_en = 1'b1;
        #1;
        chk("R9 mbox on read bus", rd_bus, 36'h3_1415_9265);
        chk("R9 take", {35'd0, rd_mbox_take}, 36'd1);
        chk("R9 no pop", {35'd0, rd_pop}, '0);
        rstep();
        rd_en = 1'b0; size_sel = 2'b00; swap_sel = 2'b00; lo_lanes = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_long_write();
        t_word_write();
        t_byte_write();
        t_swap_write();
        t_long_read();
        t_narrow_read();
        t_cfg_hold();
        t_idle();
        t_mailbox();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule